// File: doc/BRIEF.md
# Paged Flash Erase Sequencer

This block turns one erase request into a sequence of serial-flash erase commands. The request gives a byte address and a byte length. The block first checks that the range fits inside the device and that both values are whole multiples of the page size. It then walks the range from its start address. At each step it issues either a single-page erase or an eight-page block erase, depending on the current page's alignment and on how many pages are left.

After each erase frame the block polls the device status register until the ready bit is set. A programmable idle gap separates the polls. A poll limit ends the request with an error if the device never becomes ready.

The device address sent in each frame is the page index shifted left by a per-part amount. It is not the byte address, because the pages are not a power of two in size. The bit-level serial shifter sits outside this block and is reached through a byte handshake: a start pulse with a transmit byte, answered by a done pulse with a receive byte.

Top module: `df_erase_seq`

## Requirements
- R1: A request whose address plus length exceeds PAGE_BYTES*DEV_PAGES completes with err_o set, one cycle after the request, with no serial activity.
- R2: A request whose address or length is not a whole multiple of PAGE_BYTES completes with err_o set, one cycle after the request, with no serial activity.
- R3: A valid request of length zero completes without error one cycle after the request, and sends no frame.
- R4: For each step, the opcode is 0x50 (block erase of eight pages) when the current page index has its low three bits zero and at least eight pages remain. Otherwise the opcode is 0x81 (page erase).
- R5: Each erase frame is exactly four bytes sent while spi_cs_no stays low: the opcode, then bits 23:16 of the device address, then bits 15:8, then 0x00. The device address is (byte address / PAGE_BYTES) << PAGE_SHIFT.
- R6: After each frame, spi_cs_no returns high. Status is then polled in separate two-byte transactions, each sending 0xD7 and then one more byte. The device counts as ready when bit 7 of the second received byte is 1.
- R7: Before every status poll, spi_cs_no is high for exactly poll_gap_i+1 cycles.
- R8: After a ready status, the page index advances and the remaining count drops by 8 for a block erase or by 1 for a page erase. When nothing remains, done_o pulses with err_o low.
- R9: If MAX_POLLS consecutive polls all read busy, the request ends with done_o and err_o, and no further frame is sent.
- R10: done_o is a single-cycle pulse, busy_o is high from acceptance until done, and req_i is ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Erase request strobe |
| addr_i | input | ADDR_W | Start byte address |
| len_i | input | ADDR_W | Length in bytes |
| poll_gap_i | input | GAP_W | Idle cycles between status polls, minus one |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | Completion pulse |
| err_o | output | 1 | Error qualifier, valid with done_o |
| spi_cs_no | output | 1 | Chip select, active low |
| spi_start_o | output | 1 | Start of one byte transfer |
| spi_tx_o | output | 8 | Byte to transmit |
| spi_done_i | input | 1 | Byte transfer complete |
| spi_rx_i | input | 8 | Byte received, valid with spi_done_i |

## Verification
A rejected or zero-length request moves straight from idle to the finish state. Its done_o is therefore due exactly one cycle after the request edge, and the bench samples it one nanosecond after that following edge. Frames, polls and chip-select gaps take a variable number of cycles because the byte responder inserts latency. They are recorded by a monitor at each falling clock edge and compared against a sequence the bench derives from the request once done_o has fired. The idle gap is measured as the number of falling edges with chip select high before each poll, and must equal poll_gap_i+1.

// File: rtl/df_erase_pkg.sv
package df_erase_pkg;
  localparam logic [7:0] OP_PG_ERASE  = 8'h81;
  localparam logic [7:0] OP_BLK_ERASE = 8'h50;
  localparam logic [7:0] OP_STATUS    = 8'hD7;
  localparam logic [7:0] RDY_MASK     = 8'h80;
  localparam int         BLK_PAGES    = 8;

  typedef enum logic [3:0] {
    ST_IDLE, ST_FRAME, ST_FRAME_W, ST_GAP, ST_POLL_OP, ST_POLL_OP_W,
    ST_POLL_RD, ST_POLL_RD_W, ST_NEXT, ST_FIN
  } seq_state_e;
endpackage

// File: rtl/df_req_check.sv
module df_req_check #(
  parameter int ADDR_W     = 24,
  parameter int PAGE_BYTES = 264,
  parameter int DEV_PAGES  = 512,
  parameter int PIDX_W     = 10
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] len_i,
  output logic              ok_o,
  output logic [PIDX_W-1:0] pidx_o,
  output logic [PIDX_W-1:0] npages_o
);
  localparam longint unsigned DEV_BYTES = longint'(PAGE_BYTES) * longint'(DEV_PAGES);
  localparam logic [ADDR_W-1:0] PB = ADDR_W'(PAGE_BYTES);

  logic [ADDR_W:0] end_w;
  logic            in_range, aligned;

  assign end_w    = {1'b0, addr_i} + {1'b0, len_i};
  assign in_range = end_w <= (ADDR_W+1)'(DEV_BYTES);
  assign aligned  = ((addr_i % PB) == '0) && ((len_i % PB) == '0);
  assign ok_o     = in_range && aligned;
  assign pidx_o   = PIDX_W'(addr_i / PB);
  assign npages_o = PIDX_W'(len_i / PB);
endmodule

// File: rtl/df_step_plan.sv
module df_step_plan
  import df_erase_pkg::*;
#(
  parameter int PIDX_W     = 10,
  parameter int PAGE_SHIFT = 9
) (
  input  logic [PIDX_W-1:0] pidx_i,
  input  logic [PIDX_W-1:0] left_i,
  input  logic [1:0]        byte_sel_i,
  output logic              blk_o,
  output logic [PIDX_W-1:0] step_o,
  output logic [7:0]        tx_o
);
  logic [15:0] dev_hi;

  // device address bits 23:8
  assign dev_hi = 16'((32'(pidx_i) << PAGE_SHIFT) >> 8);
  assign blk_o  = (pidx_i[2:0] == 3'd0) && (left_i >= PIDX_W'(BLK_PAGES));
  assign step_o = blk_o ? PIDX_W'(BLK_PAGES) : PIDX_W'(1);

  always_comb begin
    unique case (byte_sel_i)
      2'd0:    tx_o = blk_o ? OP_BLK_ERASE : OP_PG_ERASE;
      2'd1:    tx_o = dev_hi[15:8];
      2'd2:    tx_o = dev_hi[7:0];
      default: tx_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/df_erase_seq.sv
module df_erase_seq
  import df_erase_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int PAGE_BYTES = 264,
  parameter int PAGE_SHIFT = 9,
  parameter int DEV_PAGES  = 512,
  parameter int GAP_W      = 8,
  parameter int MAX_POLLS  = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] len_i,
  input  logic [GAP_W-1:0]  poll_gap_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              spi_cs_no,
  output logic              spi_start_o,
  output logic [7:0]        spi_tx_o,
  input  logic              spi_done_i,
  input  logic [7:0]        spi_rx_i
);
  localparam int PIDX_W = $clog2(DEV_PAGES + 1);
  localparam int PCNT_W = $clog2(MAX_POLLS + 1);

  seq_state_e        state_q;
  logic [PIDX_W-1:0] pidx_q, left_q;
  logic [1:0]        byte_q;
  logic [GAP_W-1:0]  gap_q;
  logic [PCNT_W-1:0] poll_q;
  logic              err_q;

  logic              req_ok, blk, rdy;
  logic [PIDX_W-1:0] req_pidx, req_npages, step;
  logic [7:0]        frame_tx;

  df_req_check #(
    .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .DEV_PAGES(DEV_PAGES), .PIDX_W(PIDX_W)
  ) u_check (
    .addr_i(addr_i), .len_i(len_i), .ok_o(req_ok), .pidx_o(req_pidx), .npages_o(req_npages)
  );

  df_step_plan #(.PIDX_W(PIDX_W), .PAGE_SHIFT(PAGE_SHIFT)) u_plan (
    .pidx_i(pidx_q), .left_i(left_q), .byte_sel_i(byte_q),
    .blk_o(blk), .step_o(step), .tx_o(frame_tx)
  );

  assign rdy = |(spi_rx_i & RDY_MASK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pidx_q  <= '0;
      left_q  <= '0;
      byte_q  <= '0;
      gap_q   <= '0;
      poll_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_i) begin
          err_q <= !req_ok;
          if (!req_ok || req_npages == '0) state_q <= ST_FIN;
          else begin
            pidx_q  <= req_pidx;
            left_q  <= req_npages;
            byte_q  <= '0;
            state_q <= ST_FRAME;
          end
        end
        ST_FRAME:   state_q <= ST_FRAME_W;
        ST_FRAME_W: if (spi_done_i) begin
          if (byte_q == 2'd3) begin
            gap_q   <= '0;
            poll_q  <= '0;
            state_q <= ST_GAP;
          end else begin
            byte_q  <= byte_q + 2'd1;
            state_q <= ST_FRAME;
          end
        end
        ST_GAP: begin
          if (gap_q >= poll_gap_i) state_q <= ST_POLL_OP;
          else gap_q <= gap_q + 1'b1;
        end
        ST_POLL_OP:   state_q <= ST_POLL_OP_W;
        ST_POLL_OP_W: if (spi_done_i) state_q <= ST_POLL_RD;
        ST_POLL_RD:   state_q <= ST_POLL_RD_W;
        ST_POLL_RD_W: if (spi_done_i) begin
          if (rdy) state_q <= ST_NEXT;
          else if (poll_q == PCNT_W'(MAX_POLLS - 1)) begin
            err_q   <= 1'b1;
            state_q <= ST_FIN;
          end else begin
            poll_q  <= poll_q + 1'b1;
            gap_q   <= '0;
            state_q <= ST_GAP;
          end
        end
        ST_NEXT: begin
          pidx_q <= pidx_q + step;
          left_q <= left_q - step;
          byte_q <= '0;
          state_q <= (left_q == step) ? ST_FIN : ST_FRAME;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    spi_start_o = 1'b0;
    spi_tx_o    = 8'h00;
    unique case (state_q)
      ST_FRAME:   begin spi_start_o = 1'b1; spi_tx_o = frame_tx;  end
      ST_POLL_OP: begin spi_start_o = 1'b1; spi_tx_o = OP_STATUS; end
      ST_POLL_RD: spi_start_o = 1'b1;
      default: ;
    endcase
  end

  assign spi_cs_no = !(state_q inside {ST_FRAME, ST_FRAME_W, ST_POLL_OP, ST_POLL_OP_W,
                                       ST_POLL_RD, ST_POLL_RD_W});
  assign busy_o = state_q != ST_IDLE;
  assign done_o = state_q == ST_FIN;
  assign err_o  = done_o && err_q;

  AST_START_UNDER_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_start_o |-> !spi_cs_no);  // R5
  AST_START_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_start_o |=> !spi_start_o);  // R6
  AST_BLK_FITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spi_start_o && state_q == ST_FRAME && spi_tx_o == OP_BLK_ERASE && byte_q == 2'd0)
      |-> (left_q >= PIDX_W'(BLK_PAGES)));  // R4
  AST_TRAILER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FRAME && byte_q == 2'd3) |-> spi_tx_o == 8'h00);  // R5
  AST_POLL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    poll_q < PCNT_W'(MAX_POLLS));  // R9
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);  // R10
endmodule

// File: tb/df_erase_seq_tb.sv
`timescale 1ns/1ps
module df_erase_seq_tb;
  localparam int ADDR_W = 24, PB = 264, SHIFT = 9, NPG = 512, GAP_W = 8, MAXP = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0;
  logic [ADDR_W-1:0] addr = '0, len = '0;
  logic [GAP_W-1:0] gap = '0;
  logic busy, done, err, cs_n, start, sdone;
  logic [7:0] tx, rx;

  always #2.5 clk = ~clk;

  df_erase_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .addr_i(addr), .len_i(len),
    .poll_gap_i(gap), .busy_o(busy), .done_o(done), .err_o(err),
    .spi_cs_no(cs_n), .spi_start_o(start), .spi_tx_o(tx),
    .spi_done_i(sdone), .spi_rx_i(rx)
  );

  int tests = 0, fails = 0;
  int busy_target = 0, polls_step = 0;
  logic [7:0] tb_bytes[4];
  int txn_len = 0, in_txn = 0, hi_run = 0, hi_at_fall = 0, last_kind = 0;
  logic [7:0] f_op[64], f_a1[64], f_a2[64], f_a3[64];
  int f_len[64];
  int n_frames = 0, n_polls = 0, gap_bad = 0, poll_len_bad = 0, dones = 0;
  logic last_err = 1'b0;
  int resp_delay = 0;
  logic [7:0] resp_val = 8'h00;

  initial begin sdone = 1'b0; rx = 8'h00; end

  // byte responder and transaction monitor
  initial forever begin
    @(negedge clk);
    sdone = 1'b0;
    if (resp_delay > 0) begin
      resp_delay--;
      if (resp_delay == 0) begin sdone = 1'b1; rx = resp_val; end
    end
    if (done) begin dones++; last_err = err; end
    if (!cs_n) begin
      if (in_txn == 0) begin in_txn = 1; txn_len = 0; hi_at_fall = hi_run; end
      hi_run = 0;
    end else begin
      if (in_txn != 0) begin
        in_txn = 0;
        if (tb_bytes[0] == 8'hD7) begin
          n_polls++; polls_step++;
          if (txn_len != 2) poll_len_bad++;
          if (last_kind != 0 && hi_at_fall != int'(gap) + 1) gap_bad++;
          last_kind = 2;
        end else begin
          if (n_frames < 64) begin
            f_op[n_frames] = tb_bytes[0]; f_a1[n_frames] = tb_bytes[1];
            f_a2[n_frames] = tb_bytes[2]; f_a3[n_frames] = tb_bytes[3];
            f_len[n_frames] = txn_len;
          end
          n_frames++; polls_step = 0; last_kind = 1;
        end
      end
      hi_run++;
    end
    if (start) begin
      if (txn_len < 4) tb_bytes[txn_len] = tx;
      resp_val = 8'h00;
      if (txn_len == 1 && tb_bytes[0] == 8'hD7)
        resp_val = (polls_step >= busy_target) ? 8'h80 : 8'h7F;
      txn_len++;
      resp_delay = 2;
    end
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic clear_logs();
    n_frames = 0; n_polls = 0; gap_bad = 0; poll_len_bad = 0; dones = 0; last_kind = 0;
  endtask

  task automatic pulse_req(input int a, input int l);
    @(posedge clk); #1;
    addr = ADDR_W'(a); len = ADDR_W'(l); req = 1'b1;
    @(posedge clk); #1;
    req = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk); #1;
      if (dones > 0) begin ok = 1'b1; break; end
    end
    @(posedge clk); #1;
  endtask

  // immediate rejection or empty request: done due one cycle after req
  task automatic t_quick(input int a, input int l, input bit exp_err, input string rq);
    clear_logs();
    pulse_req(a, l);
    chk(done === 1'b1, rq, int'(done), 1);
    chk(err === exp_err, rq, int'(err), int'(exp_err));
    repeat (4) @(posedge clk); #1;
    chk(n_frames == 0 && cs_n === 1'b1, rq, n_frames, 0);
  endtask

  // full erase run compared against sequence derived from R4/R5/R8
  task automatic t_run(input int a, input int l, input int g, input int bt);
    bit ok;
    int p, left, k, da, exp_op;
    bit blk;
    gap = GAP_W'(g); busy_target = bt;
    clear_logs();
    pulse_req(a, l);
    chk(busy === 1'b1, "R10 busy", int'(busy), 1);
    wait_done(ok);
    chk(ok, "R8 done", int'(ok), 1);
    chk(last_err == 1'b0, "R8 err", int'(last_err), 0);
    chk(busy === 1'b0, "R10 idle", int'(busy), 0);
    p = a / PB; left = l / PB; k = 0;
    while (left > 0) begin
      blk = (p % 8 == 0) && (left >= 8);
      exp_op = blk ? 8'h50 : 8'h81;
      da = p << SHIFT;
      if (k < n_frames && k < 64) begin
        chk(int'(f_op[k]) == exp_op, "R4 opcode", int'(f_op[k]), exp_op);
        chk(int'(f_a1[k]) == ((da >> 16) & 255), "R5 addr hi", int'(f_a1[k]), (da >> 16) & 255);
        chk(int'(f_a2[k]) == ((da >> 8) & 255), "R5 addr mid", int'(f_a2[k]), (da >> 8) & 255);
        chk(f_a3[k] == 8'h00 && f_len[k] == 4, "R5 trailer/len", f_len[k], 4);
      end
      p += blk ? 8 : 1; left -= blk ? 8 : 1; k++;
    end
    chk(n_frames == k, "R8 frame count", n_frames, k);
    chk(n_polls == k * (bt + 1), "R6 poll count", n_polls, k * (bt + 1));
    chk(poll_len_bad == 0, "R6 poll length", poll_len_bad, 0);
    chk(gap_bad == 0, "R7 gap", gap_bad, 0);
  endtask

  task automatic t_timeout();
    bit ok;
    gap = '0; busy_target = 100000;
    clear_logs();
    pulse_req(16 * PB, 2 * PB);
    wait_done(ok);
    chk(ok && last_err == 1'b1, "R9 err", int'(last_err), 1);
    chk(n_polls == MAXP, "R9 polls", n_polls, MAXP);
    chk(n_frames == 1, "R9 frames", n_frames, 1);
  endtask

  task automatic t_ignore_busy();
    bit ok;
    gap = 8'd1; busy_target = 0;
    clear_logs();
    pulse_req(0, 3 * PB);
    repeat (6) @(posedge clk); #1;
    addr = ADDR_W'(1); len = ADDR_W'(5); req = 1'b1;
    @(posedge clk); #1; req = 1'b0;
    wait_done(ok);
    repeat (5) @(posedge clk); #1;
    chk(dones == 1, "R10 single done", dones, 1);
    chk(last_err == 1'b0, "R10 ignored req", int'(last_err), 0);
    chk(n_frames == 3, "R10 frames", n_frames, 3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk(cs_n === 1'b1 && start === 1'b0, "R10 reset spi", int'(start), 0);
    chk(done === 1'b0 && busy === 1'b0, "R10 reset idle", int'(busy), 0);
    t_quick(511 * PB, 2 * PB, 1'b1, "R1 out of range");
    t_quick(NPG * PB, 0, 1'b0, "R3 empty at end");
    t_quick(100, PB, 1'b1, "R2 misaligned addr");
    t_quick(PB, 10, 1'b1, "R2 misaligned len");
    t_quick(0, 0, 1'b0, "R3 zero length");
    t_run(504 * PB, 8 * PB, 2, 0);
    t_run(5 * PB, 12 * PB, 3, 2);
    t_run(8 * PB, 7 * PB, 0, 1);
    t_run(0, NPG * PB, 1, 0);
    t_run(40 * PB, 17 * PB, 5, 3);
    t_timeout();
    t_ignore_busy();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule